// File: doc/BRIEF.md
# Serial Debug RAM Rewrite Engine

This block is the target end of a debug link. It lets an external host overwrite one 32-bit word of on-chip RAM while the processor keeps running. The host drives a serial clock and a receive line and exchanges 32-bit frames, least-significant bit first. A write starts with a command frame that holds the command code and the byte address. A data frame follows. In the frame after that, the engine reads the target word, writes the new value and reads the word back. It uses only cycles in which the CPU leaves the RAM idle.

The host then collects two results on the transmit line. The frame after the execution frame carries the old value of the word, and the frame after that carries the value read back after the write. An acknowledge line rises once all three RAM accesses are done. The block samples the serial clock and data with the system clock, so each half period of the serial clock must last at least six system clocks. Frame counting starts at the first serial clock after reset.

Top module: `dbgp_ram_patch`

## Requirements
- R1: After reset, `ser_tx` is high, `ser_ack` is low and `ram_req` is low.
- R2: A frame is 32 serial clock rising edges, sampled LSB first. In a command frame, bits [19:16] hold the code, with 4'h5 = write and 4'h9 = recover, and bits [15:0] hold the byte address, of which the low ADDR_W bits are used. The frame after a write command is taken as the 32-bit write data.
- R3: After a write sequence, the addressed RAM word holds the write data. Exactly one RAM write is made per accepted write command.
- R4: In the frame after the execution frame, `ser_tx` carries, LSB first, the content of the word just before the write.
- R5: In the frame after the before-value frame, `ser_tx` carries, LSB first, the value read back just after the write.
- R6: Byte address bits [1:0] are ignored. The word address is byte address bits [ADDR_W-1:2].
- R7: The engine never requests the RAM in a cycle where `cpu_busy` is high. Its three accesses come in the order read, write, read.
- R8: If `cpu_busy` holds the RAM through a whole execution frame, execution continues into the following frames. `ser_tx` stays high in those frames, and the before and after values move back by whole frames.
- R9: `ser_ack` stays low until the three accesses are complete. It then stays high until the end of the before-value frame and is low in every other frame.
- R10: After a recover command, the next command frame is ignored unless its bits [31:20] are all ones. Any command frame clears this condition.
- R11: Frames that arrive during the data, execution and return frames are not decoded as commands. Codes other than 4'h5 and 4'h9 have no effect. `ser_tx` is high outside the two return frames.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ser_clk | input | 1 | Serial clock from the host |
| ser_rx | input | 1 | Serial data from the host, sampled on the rising edge |
| ser_tx | output | 1 | Serial data to the host, updated after the falling edge |
| ser_ack | output | 1 | Rewrite-complete indication |
| cpu_busy | input | 1 | CPU owns the RAM in this cycle |
| ram_req | output | 1 | Engine RAM access in this cycle |
| ram_we | output | 1 | Access is a write (valid with `ram_req`) |
| ram_addr | output | ADDR_W-2 | Word address |
| ram_wdata | output | 32 | Write data |
| ram_rdata | input | 32 | Read data, valid the cycle after a read request |

## Verification
A wrong frame state shows up as a whole frame of wrong bits on `ser_tx` within one frame. Examples are a before value returned one frame early, an all-ones frame where data was due, or an acknowledge in the wrong frame. A wrong access-sequencer state shows up at once on the RAM port, as a request while `cpu_busy` is high, a write without a read before it, or a second write. It shows up again one or two frames later as a returned value that differs from the bench's copy of the memory. Decoy write commands sent inside the busy frames would leave a changed word at a second address if the command decoder ran when it should not.

// File: rtl/dbgp_pkg.sv
package dbgp_pkg;
    localparam int FRAME_BITS = 32;
    localparam int CODE_LSB   = 16;
    localparam int GUARD_LSB  = 20;

    localparam logic [3:0] CMD_WRITE   = 4'h5;
    localparam logic [3:0] CMD_RECOVER = 4'h9;

    // Position of each frame relative to a write command
    typedef enum logic [2:0] {
        F_CMD, F_DATA, F_EXEC, F_PRE, F_POST
    } frame_st_e;

    // RAM access sequence: read, capture, write, read back, capture
    typedef enum logic [2:0] {
        A_IDLE, A_RD, A_RDW, A_WR, A_VR, A_VRW
    } acc_st_e;
endpackage

// File: rtl/dbgp_serial.sv
module dbgp_serial
    import dbgp_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  ser_clk,
    input  logic                  ser_rx,
    input  logic                  tx_en,
    input  logic [FRAME_BITS-1:0] tx_word,
    output logic                  frame_vld,
    output logic [FRAME_BITS-1:0] frame_word,
    output logic                  ser_tx
);
    localparam int CW = $clog2(FRAME_BITS);

    typedef struct packed {
        logic [2:0]            ck;
        logic [1:0]            rx;
        logic [CW-1:0]         cnt;
        logic [FRAME_BITS-1:0] sh;
        logic [FRAME_BITS-1:0] word;
        logic                  vld;
        logic                  tx;
    } ser_t;

    ser_t q, d;
    logic rise, fall;

    always_comb begin
        d     = q;
        d.vld = 1'b0;
        d.ck  = {q.ck[1:0], ser_clk};
        d.rx  = {q.rx[0], ser_rx};
        rise  = q.ck[1] & ~q.ck[2];
        fall  = ~q.ck[1] & q.ck[2];
        if (rise) begin
            // LSB arrives first, so shift in from the top
            d.sh = {q.rx[1], q.sh[FRAME_BITS-1:1]};
            if (q.cnt == CW'(FRAME_BITS - 1)) begin
                d.cnt  = '0;
                d.word = {q.rx[1], q.sh[FRAME_BITS-1:1]};
                d.vld  = 1'b1;
            end else begin
                d.cnt = q.cnt + 1'b1;
            end
        end
        if (fall) begin
            d.tx = tx_en ? tx_word[q.cnt] : 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q    <= '0;
            q.tx <= 1'b1;
        end else begin
            q <= d;
        end
    end

    assign frame_vld  = q.vld;
    assign frame_word = q.word;
    assign ser_tx     = q.tx;
endmodule

// File: rtl/dbgp_ctrl.sv
module dbgp_ctrl
    import dbgp_pkg::*;
#(
    parameter int ADDR_W = 10
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  frame_vld,
    input  logic [FRAME_BITS-1:0] frame_word,
    input  logic                  acc_done,
    input  logic [FRAME_BITS-1:0] pre_val,
    input  logic [FRAME_BITS-1:0] post_val,
    output logic                  acc_start,
    output logic [ADDR_W-3:0]     acc_addr,
    output logic [FRAME_BITS-1:0] acc_wdata,
    output logic                  tx_en,
    output logic [FRAME_BITS-1:0] tx_word,
    output logic                  ack
);
    localparam int GUARD_W = FRAME_BITS - GUARD_LSB;

    typedef struct packed {
        frame_st_e             st;
        logic                  rcv;
        logic                  done;
        logic                  start;
        logic [ADDR_W-3:0]     addr;
        logic [FRAME_BITS-1:0] wdata;
    } ctrl_t;

    ctrl_t q, d;
    logic [3:0] code;
    logic       guard_ok;

    assign code     = frame_word[CODE_LSB +: 4];
    assign guard_ok = (frame_word[GUARD_LSB +: GUARD_W] == {GUARD_W{1'b1}});

    always_comb begin
        d       = q;
        d.start = 1'b0;
        if (acc_done) d.done = 1'b1;
        if (frame_vld) begin
            unique case (q.st)
                F_CMD: begin
                    d.rcv = 1'b0;
                    if (!q.rcv || guard_ok) begin
                        if (code == CMD_WRITE) begin
                            d.st   = F_DATA;
                            d.addr = frame_word[ADDR_W-1:2];
                        end else if (code == CMD_RECOVER) begin
                            d.rcv = 1'b1;
                        end
                    end
                end
                F_DATA: begin
                    d.wdata = frame_word;
                    d.start = 1'b1;
                    d.done  = 1'b0;
                    d.st    = F_EXEC;
                end
                F_EXEC: begin
                    if (q.done || acc_done) d.st = F_PRE;
                end
                F_PRE: begin
                    d.done = 1'b0;
                    d.st   = F_POST;
                end
                F_POST:  d.st = F_CMD;
                default: d.st = F_CMD;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign acc_start = q.start;
    assign acc_addr  = q.addr;
    assign acc_wdata = q.wdata;
    assign tx_en     = (q.st == F_PRE) || (q.st == F_POST);
    assign tx_word   = (q.st == F_PRE) ? pre_val : post_val;
    assign ack       = q.done && ((q.st == F_EXEC) || (q.st == F_PRE));
endmodule

// File: rtl/dbgp_ramseq.sv
module dbgp_ramseq
    import dbgp_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  start,
    input  logic                  cpu_busy,
    input  logic [FRAME_BITS-1:0] ram_rdata,
    output logic                  ram_req,
    output logic                  ram_we,
    output logic                  done,
    output logic [FRAME_BITS-1:0] pre_val,
    output logic [FRAME_BITS-1:0] post_val
);
    typedef struct packed {
        acc_st_e               st;
        logic                  done;
        logic [FRAME_BITS-1:0] pre;
        logic [FRAME_BITS-1:0] post;
    } seq_t;

    seq_t q, d;

    always_comb begin
        d       = q;
        d.done  = 1'b0;
        ram_req = 1'b0;
        ram_we  = 1'b0;
        unique case (q.st)
            A_IDLE: if (start) d.st = A_RD;
            A_RD: if (!cpu_busy) begin
                ram_req = 1'b1;
                d.st    = A_RDW;
            end
            A_RDW: begin
                d.pre = ram_rdata;
                d.st  = A_WR;
            end
            A_WR: if (!cpu_busy) begin
                ram_req = 1'b1;
                ram_we  = 1'b1;
                d.st    = A_VR;
            end
            A_VR: if (!cpu_busy) begin
                ram_req = 1'b1;
                d.st    = A_VRW;
            end
            A_VRW: begin
                d.post = ram_rdata;
                d.done = 1'b1;
                d.st   = A_IDLE;
            end
            default: d.st = A_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign done     = q.done;
    assign pre_val  = q.pre;
    assign post_val = q.post;
endmodule

// File: rtl/dbgp_ram_patch.sv
module dbgp_ram_patch
    import dbgp_pkg::*;
#(
    parameter int ADDR_W = 10
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  ser_clk,
    input  logic                  ser_rx,
    output logic                  ser_tx,
    output logic                  ser_ack,
    input  logic                  cpu_busy,
    output logic                  ram_req,
    output logic                  ram_we,
    output logic [ADDR_W-3:0]     ram_addr,
    output logic [FRAME_BITS-1:0] ram_wdata,
    input  logic [FRAME_BITS-1:0] ram_rdata
);
    logic                  frame_vld;
    logic [FRAME_BITS-1:0] frame_word;
    logic                  tx_en;
    logic [FRAME_BITS-1:0] tx_word;
    logic                  acc_start;
    logic                  acc_done;
    logic [FRAME_BITS-1:0] pre_val;
    logic [FRAME_BITS-1:0] post_val;

    dbgp_serial u_ser (
        .clk        (clk),
        .rst_n      (rst_n),
        .ser_clk    (ser_clk),
        .ser_rx     (ser_rx),
        .tx_en      (tx_en),
        .tx_word    (tx_word),
        .frame_vld  (frame_vld),
        .frame_word (frame_word),
        .ser_tx     (ser_tx)
    );

    dbgp_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .frame_vld  (frame_vld),
        .frame_word (frame_word),
        .acc_done   (acc_done),
        .pre_val    (pre_val),
        .post_val   (post_val),
        .acc_start  (acc_start),
        .acc_addr   (ram_addr),
        .acc_wdata  (ram_wdata),
        .tx_en      (tx_en),
        .tx_word    (tx_word),
        .ack        (ser_ack)
    );

    dbgp_ramseq u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (acc_start),
        .cpu_busy  (cpu_busy),
        .ram_rdata (ram_rdata),
        .ram_req   (ram_req),
        .ram_we    (ram_we),
        .done      (acc_done),
        .pre_val   (pre_val),
        .post_val  (post_val)
    );
endmodule

// File: rtl/dbgp_ram_patch_chk.sv
module dbgp_ram_patch_chk (
    input logic clk,
    input logic rst_n,
    input logic cpu_busy,
    input logic ram_req,
    input logic ram_we,
    input logic ser_ack
);
    logic last_rd_q;
    logic wr_seen_q;
    logic ack_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            last_rd_q <= 1'b0;
            wr_seen_q <= 1'b0;
            ack_q     <= 1'b0;
        end else begin
            ack_q <= ser_ack;
            if (ram_req) last_rd_q <= !ram_we;
            if (ram_req && ram_we)    wr_seen_q <= 1'b1;
            else if (ack_q && !ser_ack) wr_seen_q <= 1'b0;
        end
    end

    // R7
    no_busy_access_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ram_req |-> !cpu_busy);

    // R7
    write_after_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ram_req && ram_we) |-> last_rd_q);

    // R9
    ack_after_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ser_ack && !ack_q) |-> wr_seen_q);

    // R3
    single_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ram_req && ram_we) |-> !wr_seen_q);
endmodule

bind dbgp_ram_patch dbgp_ram_patch_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .cpu_busy (cpu_busy),
    .ram_req  (ram_req),
    .ram_we   (ram_we),
    .ser_ack  (ser_ack)
);

// File: tb/sim_dbgp_ram_patch.sv
module sim_dbgp_ram_patch;
    localparam int CLK_PERIOD = 10;
    localparam int ADDR_W     = 10;
    localparam int WAW        = ADDR_W - 2;
    localparam int DEPTH      = 1 << WAW;
    localparam int HALF       = 6;
    localparam logic [31:0] ONES = 32'hFFFF_FFFF;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ser_clk = 1'b0;
    logic ser_rx = 1'b1;
    logic ser_tx, ser_ack, ram_req, ram_we;
    logic cpu_busy = 1'b0;
    logic [WAW-1:0] ram_addr;
    logic [31:0] ram_wdata;
    logic [31:0] ram_rdata = '0;

    logic [31:0] mem [DEPTH];
    logic [31:0] ref_mem [DEPTH];
    bit busy_force = 1'b0;
    bit rnd_on = 1'b0;
    int ack_cnt = 0;
    int acc_cnt = 0;
    int viol_cnt = 0;
    int n_chk = 0;
    int n_err = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    dbgp_ram_patch #(.ADDR_W(ADDR_W)) u0 (
        .clk(clk), .rst_n(rst_n), .ser_clk(ser_clk), .ser_rx(ser_rx),
        .ser_tx(ser_tx), .ser_ack(ser_ack), .cpu_busy(cpu_busy),
        .ram_req(ram_req), .ram_we(ram_we), .ram_addr(ram_addr),
        .ram_wdata(ram_wdata), .ram_rdata(ram_rdata)
    );

    // RAM model with one-cycle read latency
    always @(posedge clk) begin
        if (ram_req) begin
            if (ram_we) mem[ram_addr] <= ram_wdata;
            ram_rdata <= mem[ram_addr];
        end
        if (ser_ack) ack_cnt <= ack_cnt + 1;
        if (ram_req) acc_cnt <= acc_cnt + 1;
        if (ram_req && cpu_busy) viol_cnt <= viol_cnt + 1;
    end

    always @(negedge clk)
        cpu_busy <= busy_force | (rnd_on && ($urandom % 100 < 40));

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // One 32-bit frame; returns the bits seen on ser_tx and whether ack was seen
    task automatic send(input logic [31:0] w, input int rel,
                        output logic [31:0] got, output bit acked);
        int a0 = ack_cnt;
        for (int k = 0; k < 32; k++) begin
            ser_rx  = w[k];
            ser_clk = 1'b0;
            if (k == rel) busy_force = 1'b0;
            repeat (HALF) @(negedge clk);
            got[k]  = ser_tx;
            ser_clk = 1'b1;
            repeat (HALF) @(negedge clk);
        end
        acked = (ack_cnt != a0);
    endtask

    task automatic do_write(input logic [11:0] guard, input logic [15:0] baddr,
                            input logic [31:0] data, input bit long_busy);
        logic [31:0] got, junk;
        bit ak;
        logic [WAW-1:0] wa = baddr[ADDR_W-1:2];
        logic [WAW-1:0] decoy = wa ^ WAW'(1 << (WAW - 1));
        int acc0;
        junk = {12'hFFF, 4'h5, 16'(decoy) << 2};
        if (long_busy) busy_force = 1'b1;
        send({guard, 4'h5, baddr}, -1, got, ak);
        chk(got == ONES && !ak, "R11", "tx/ack in command frame", got, ONES);
        acc0 = acc_cnt;
        send(data, -1, got, ak);
        chk(got == ONES && !ak, "R9", "tx/ack in data frame", got, ONES);
        send(junk, -1, got, ak);
        chk(got == ONES, "R11", "tx in execution frame", got, ONES);
        if (long_busy) begin
            chk(!ak, "R8", "no ack while RAM held busy", 32'(ak), 32'd0);
            send(junk, 16, got, ak);
            chk(got == ONES, "R8", "tx in extended execution frame", got, ONES);
        end
        chk(ak, "R9", "ack after access", 32'(ak), 32'd1);
        send(junk, -1, got, ak);
        chk(got == ref_mem[wa], "R4", "before value", got, ref_mem[wa]);
        chk(ak, "R9", "ack held in before-value frame", 32'(ak), 32'd1);
        send(junk, -1, got, ak);
        chk(got == data, "R5", "after value", got, data);
        chk(!ak, "R9", "ack low in after-value frame", 32'(ak), 32'd0);
        ref_mem[wa] = data;
        chk(mem[wa] == data, "R3", "RAM word written", mem[wa], data);
        chk(acc_cnt - acc0 == 3, "R7", "three RAM accesses", 32'(acc_cnt - acc0), 32'd3);
        chk(mem[decoy] == ref_mem[decoy], "R11", "decoy word untouched",
            mem[decoy], ref_mem[decoy]);
    endtask

    // Sends frames that must not start a write; checks tx, ack and RAM stay idle
    task automatic quiet_frames(input int n, input logic [WAW-1:0] wa, input string req);
        logic [31:0] got;
        bit ak;
        int acc0 = acc_cnt;
        for (int i = 0; i < n; i++) begin
            send(ONES, -1, got, ak);
            chk(got == ONES && !ak, req, "idle frame", got, ONES);
        end
        chk(acc_cnt == acc0 && mem[wa] == ref_mem[wa], req, "no RAM change",
            mem[wa], ref_mem[wa]);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_err++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

    initial begin
        logic [31:0] got;
        bit ak;
        void'($urandom(32'd4711));
        for (int i = 0; i < DEPTH; i++) begin
            mem[i]     = $urandom;
            ref_mem[i] = mem[i];
        end
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        // R1
        chk(ser_tx == 1'b1, "R1", "tx after reset", 32'(ser_tx), 32'd1);
        chk(ser_ack == 1'b0, "R1", "ack after reset", 32'(ser_ack), 32'd0);
        chk(ram_req == 1'b0, "R1", "ram_req after reset", 32'(ram_req), 32'd0);
        rnd_on = 1'b1;

        // R2: directed write with a known pattern
        do_write(12'h000, 16'h0010, 32'hA5C3_0F81, 1'b0);
        // R8: CPU holds the RAM for the whole execution frame
        do_write(12'h5A5, 16'h0040, 32'h1234_5678, 1'b1);
        // R6: low byte-address bits set
        do_write(12'h3C3, 16'h0087, 32'h0BAD_F00D, 1'b0);
        chk(mem[8'h21] == 32'h0BAD_F00D, "R6", "word address ignores bits 1:0",
            mem[8'h21], 32'h0BAD_F00D);

        // R2: random writes under random CPU load
        for (int t = 0; t < 8; t++) begin
            do_write(12'($urandom), 16'($urandom), $urandom, 1'b0);
        end

        // R10: recover, then a write without the all-ones guard is dropped
        send({12'h0AB, 4'h9, 16'h1234}, -1, got, ak);
        chk(got == ONES && !ak, "R10", "recover frame idle", got, ONES);
        send({12'h7FF, 4'h5, 16'h0020}, -1, got, ak);
        quiet_frames(4, 8'h08, "R10");
        // R10: recover, then a guarded write is accepted
        send({12'h000, 4'h9, 16'h0000}, -1, got, ak);
        do_write(12'hFFF, 16'h0020, 32'hCAFE_0042, 1'b0);
        // R10: any command frame clears the recover condition
        send({12'h000, 4'h9, 16'h0000}, -1, got, ak);
        send(ONES, -1, got, ak);
        do_write(12'h000, 16'h0030, 32'h7E57_0003, 1'b0);
        // R11: unknown code has no effect
        send({12'h000, 4'h3, 16'h0050}, -1, got, ak);
        quiet_frames(3, 8'h14, "R11");

        chk(viol_cnt == 0, "R7", "accesses while CPU busy", 32'(viol_cnt), 32'd0);
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end
endmodule